// File: doc/BRIEF.md
# Configurable serial sample output formatter

This block turns one parallel converter sample per frame into a serial word on a single data line. It also drives a frame marker and a bit-rate data clock. All timing comes from one fast clock. Each serial bit lasts `SUB` cycles of that clock (12 by default), and the data clock is built from the same sub-step counter. This lets its phase be placed on exact sub-step boundaries relative to the data edges.

Configuration is applied only when a word starts. The configuration inputs select:
- the word length: 8, 10, 12 or 14 bits;
- the bit order: most significant bit first, or least significant bit first;
- the data polarity: normal or inverted;
- the data clock phase.

Short words keep the most significant sample bits. A 14-bit word carries the full sample followed by two zero bits. Least-significant-first order sends the same word in exactly reversed order. Inversion is applied after the ordering, so the two options combine freely.

The parallel side uses a valid/ready handshake. `s_ready` pulses for one cycle in the last sub-step of every word. If `s_valid` is high in that cycle, the new sample is taken. Otherwise the last accepted sample is sent again, formatted with the configuration present at that boundary.

Top module: `serial_word_formatter`

## Requirements
- R1: With `cfg_len`=2 (12 bits) and `cfg_lsb_first`=0, each word sends sample bit 11 first and bit 0 last, one bit per `SUB` clock cycles.
- R2: With `cfg_lsb_first`=1, each word is the exact reverse of the word that would be sent most-significant-first with the same length.
- R3: With `cfg_invert`=1, every bit on `ser_data` is the complement of the bit that would otherwise be sent. Inversion combines with either bit order.
- R4: `cfg_len`=0 sends 8 bits (sample bits 11 down to 4) and `cfg_len`=1 sends 10 bits (sample bits 11 down to 2). The next word starts right after the last of these bits.
- R5: `cfg_len`=3 sends 14 bits: the 12 sample bits, most significant first, followed by two 0 bits. In least-significant-first order the two 0 bits come first.
- R6: `ser_frame` is high for exactly the `SUB` cycles of the first bit of each word and low otherwise.
- R7: `ser_dclk` has a period of `SUB` cycles and is high for `SUB`/2 of them. Its rising edge lies a fixed number of sub-steps after the data edge, chosen by `cfg_phase`:
  - code 1: 0 steps (0°);
  - code 2: 2 steps (60°);
  - code 3: 4 steps (120°);
  - code 4: 6 steps (180°);
  - code 5: 8 steps (240°);
  - code 6: 10 steps (300°).
- R8: `cfg_phase` codes 0 and 7 give the default phase of 3 sub-steps (90°).
- R9: Changes of `cfg_len`, `cfg_lsb_first`, `cfg_invert` and `cfg_phase` take effect only at the next word boundary. They never alter a word already in progress.
- R10: `s_ready` is high only in the final cycle of each word. A sample is taken when `s_valid` and `s_ready` are both high. Without a new sample, the last accepted sample (0 after reset) is sent again.
- R11: During reset and in the first cycle after it, `ser_data`, `ser_frame` and `ser_dclk` are 0. The first word starts in the first clock cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sub-step clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | DW | Parallel sample |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Word boundary; sample accepted this cycle if valid |
| cfg_len | input | 2 | Word length: 0=8, 1=10, 2=12, 3=14 bits |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_invert | input | 1 | 1 = invert serial data |
| cfg_phase | input | 3 | Data clock phase code |
| ser_data | output | 1 | Serial data |
| ser_frame | output | 1 | High during the first bit of each word |
| ser_dclk | output | 1 | Data clock, one period per bit |

## Verification
Each fault in the sub-step counter, the bit counter or the latched word length moves either the frame marker or the ready pulse. That shift shows up at the ports within one word. A wrong phase offset shows up within one bit period.

A faulty bit extraction, reversal or inversion corrupts `ser_data` in the first word that uses the affected mode.

A configuration captured in the middle of a word bends that same word. Changing the configuration every cycle therefore exposes it at once.

Every cycle of every output is compared against a behavioural model. A fault is reported in the cycle it first appears.

// File: rtl/serial_word_formatter.sv
module serial_word_formatter #(
  parameter int DW   = 12,
  parameter int SUB  = 12,
  parameter int MAXW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] s_data,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_lsb_first,
  input  logic          cfg_invert,
  input  logic [2:0]    cfg_phase,
  output logic          ser_data,
  output logic          ser_frame,
  output logic          ser_dclk
);

  localparam int SW   = $clog2(SUB);
  localparam int BW   = $clog2(MAXW);
  localparam int HALF = SUB / 2;
  localparam int STEP = SUB / 6;
  localparam int DEFP = SUB / 4;

  logic [SW-1:0]   sub_q, off_q, off_n;
  logic [BW-1:0]   bit_q, last_q;
  logic [MAXW-1:0] word_q, word_n, mseq;
  logic [DW-1:0]   hold_q, src;
  logic            inv_q, at_end;
  int              nlen;

  assign at_end  = (sub_q == SW'(SUB-1)) && (bit_q == last_q);
  assign s_ready = rst_n && at_end;
  assign src     = s_valid ? s_data : hold_q;

  genvar k;
  for (k = 0; k < MAXW; k++) begin : g_seq
    if (k < DW) begin : g_bit
      assign mseq[k] = src[DW-1-k];
    end else begin : g_pad
      assign mseq[k] = 1'b0;
    end
  end

  always_comb begin
    case (cfg_len)
      2'd0:    nlen = 8;
      2'd1:    nlen = 10;
      2'd2:    nlen = 12;
      default: nlen = 14;
    endcase
    word_n = '0;
    for (int i = 0; i < MAXW; i++)
      if (i < nlen)
        word_n[i] = cfg_lsb_first ? mseq[BW'(nlen-1-i)] : mseq[i];
    case (cfg_phase)
      3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6:
        off_n = SW'((int'(cfg_phase) - 1) * STEP);
      default: off_n = SW'(DEFP);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q  <= SW'(SUB-1);
      bit_q  <= BW'(MAXW-1);
      last_q <= BW'(MAXW-1);
      word_q <= '0;
      hold_q <= '0;
      inv_q  <= 1'b0;
      off_q  <= SW'(DEFP);
    end else if (at_end) begin
      sub_q  <= '0;
      bit_q  <= '0;
      last_q <= BW'(nlen-1);
      word_q <= word_n;
      inv_q  <= cfg_invert;
      off_q  <= off_n;
      if (s_valid) hold_q <= s_data;
    end else if (sub_q == SW'(SUB-1)) begin
      sub_q <= '0;
      bit_q <= bit_q + 1'b1;
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

  int dpos;
  always_comb begin
    dpos = int'(sub_q) - int'(off_q);
    if (dpos < 0) dpos = dpos + SUB;
  end

  assign ser_data  = inv_q ^ word_q[bit_q];
  assign ser_frame = (bit_q == '0);
  assign ser_dclk  = (dpos < HALF);

  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  a_r6_frame_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> ser_frame);

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |=> ($stable(last_q) && $stable(inv_q) && $stable(off_q) && $stable(word_q)));

  a_r7_dclk_high_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_dclk) |=> ser_dclk);

  a_r6_frame_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_frame) |-> !s_ready);

endmodule

// File: tb/serial_word_formatter_test.sv
module serial_word_formatter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] s_data = '0;
  logic s_valid = 1'b0;
  logic [1:0] cfg_len = 2'd2;
  logic cfg_lsb_first = 1'b0, cfg_invert = 1'b0;
  logic [2:0] cfg_phase = 3'd0;
  logic s_ready, ser_data, ser_frame, ser_dclk;

  serial_word_formatter uut (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first), .cfg_invert(cfg_invert),
    .cfg_phase(cfg_phase), .ser_data(ser_data), .ser_frame(ser_frame), .ser_dclk(ser_dclk));

  always #5 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0;
  int msub = 11, mbit = 13, mlast = 13, moff = 3;
  bit mex[14];
  bit minv = 0;
  logic [11:0] mhold = '0;
  string tag = "R11";

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic bit exp_ready();
    return rst_n && msub == 11 && mbit == mlast;
  endfunction

  task automatic model_step();
    if (!rst_n) begin
      msub = 11; mbit = 13; mlast = 13; moff = 3; minv = 0; mhold = '0;
      foreach (mex[i]) mex[i] = 0;
    end else if (exp_ready()) begin
      int len;
      if (s_valid) mhold = s_data;
      len = 8 + 2 * int'(cfg_len);
      foreach (mex[i]) mex[i] = 0;
      for (int i = 0; i < len; i++) begin
        int idx = cfg_lsb_first ? len - 1 - i : i;
        mex[i] = (idx < 12) ? mhold[11-idx] : 1'b0;
      end
      mlast = len - 1;
      minv = cfg_invert;
      moff = (cfg_phase == 0 || cfg_phase == 7) ? 3 : (int'(cfg_phase) - 1) * 2;
      msub = 0; mbit = 0;
    end else begin
      msub++;
      if (msub == 12) begin msub = 0; mbit++; end
    end
  endtask

  task automatic chk(string what, string t, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", t, what, cyc, act, exp);
    end
  endtask

  task automatic compare();
    bit e_d, e_f, e_c, e_r;
    int d;
    e_r = exp_ready();
    e_d = minv ^ mex[mbit];
    e_f = (mbit == 0);
    d = (msub - moff + 12) % 12;
    e_c = (d < 6);
    chk("ser_data", tag, ser_data, e_d);
    chk("ser_frame", (tag == "R11") ? "R11" : "R6", ser_frame, e_f);
    chk("ser_dclk", (tag == "R11") ? "R11" : (tag == "R8" ? "R8" : "R7"), ser_dclk, e_c);
    chk("s_ready", "R10", s_ready, e_r);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic run_words(int n, bit valid_on, bit cfg_churn);
    int got = 0;
    while (got < n) begin
      s_valid = valid_on;
      s_data = 12'($urandom);
      if (cfg_churn) begin
        cfg_len = 2'($urandom); cfg_lsb_first = 1'($urandom);
        cfg_invert = 1'($urandom); cfg_phase = 3'($urandom);
      end
      if (exp_ready()) got++;
      tick();
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) tick();
    rst_n = 1'b1;
    tick();
    tag = "R1";
    run_words(4, 1, 0);
    tag = "R2"; cfg_lsb_first = 1; run_words(3, 1, 0);
    tag = "R3"; cfg_invert = 1; run_words(3, 1, 0);
    cfg_lsb_first = 0; run_words(2, 1, 0);
    cfg_invert = 0;
    tag = "R4"; cfg_len = 0; run_words(3, 1, 0);
    cfg_len = 1; run_words(3, 1, 0);
    cfg_lsb_first = 1; run_words(2, 1, 0);
    cfg_len = 0; run_words(2, 1, 0);
    tag = "R5"; cfg_len = 3; cfg_lsb_first = 0; run_words(3, 1, 0);
    cfg_lsb_first = 1; cfg_invert = 1; run_words(3, 1, 0);
    cfg_lsb_first = 0; cfg_invert = 0; cfg_len = 2;
    tag = "R7";
    for (int p = 1; p <= 6; p++) begin cfg_phase = 3'(p); run_words(2, 1, 0); end
    tag = "R8"; cfg_phase = 7; run_words(2, 1, 0);
    cfg_phase = 0; run_words(2, 1, 0);
    tag = "R10"; run_words(4, 0, 0);
    cfg_len = 0; cfg_lsb_first = 1; run_words(2, 0, 0);
    tag = "R9"; run_words(20, 1, 1);
    run_words(6, 0, 1);
    tag = "R11"; rst_n = 0; tick(); tick();
    rst_n = 1; tick();
    tag = "R1"; cfg_len = 2; cfg_lsb_first = 0; cfg_invert = 0; cfg_phase = 0;
    run_words(2, 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule